// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Status

This block receives characters from an asynchronous serial line. The line first passes through a two-flop synchronizer. A single-cycle enable, pulsing sixteen times per bit period, then paces a bit-timing controller. That controller validates each start bit, samples the data bits, the optional parity bit and one or two stop bits at their centres, and reports each finished frame to a datapath. The datapath assembles the character LSB first and right-aligns it. It stores the character in a 16-entry FIFO together with three error tags.

The host side pops characters from the FIFO. The oldest character and its tags are always visible at the outputs. Four sticky line-status flags (overrun, parity, framing, break) clear on a status-read strobe. An aggregate flag shows whether any stored character carries an error tag. An interrupt request asserts once the FIFO fill reaches a selectable threshold. A clear strobe empties the FIFO.

Top module: `serial_rx_top`

## Requirements
- R1: `dataReady` is 1 exactly while the FIFO holds a character; `rxData` shows the oldest character, received LSB first and right-aligned, with `cfgWordLen` codes 00, 01, 10, 11 selecting 5, 6, 7, 8 data bits.
- R2: A low level on the synchronized line starts a frame only if the line is still low at the 8th tick after detection; otherwise no character is produced.
- R3: With `cfgParEn`=1, a parity bit follows the data; `cfgParSel` 00 = odd, 01 = even, 10 = bit always 1, 11 = bit always 0; a mismatch tags the character and sets `parityErr`.
- R4: A stop sample of 0 (one stop bit, or either of two when `cfgTwoStop`=1) tags the character and sets `framingErr`.
- R5: A frame whose every sample, stop bits included, is 0 stores one character of value 0 tagged break and framing (parity not tagged) and sets `breakInd`; no further frame starts until the line has returned high.
- R6: A frame that completes while the FIFO holds 16 characters is discarded; the FIFO contents are unchanged and `overrunErr` is set.
- R7: A `lsrRead` pulse clears `overrunErr`, `parityErr`, `framingErr` and `breakInd`; an event in the same cycle wins over the clear.
- R8: `fifoErrAny` is 1 while at least one stored character carries any error tag; it is unaffected by `lsrRead`.
- R9: `irqReq` is 1 while the fill level is at least 1, 4, 8 or 14 for `cfgTrig` codes 00, 01, 10, 11.
- R10: `fifoClr` empties the FIFO and clears `fifoErrAny` in the next cycle.
- R11: `headTags` shows the oldest character's tags as {break, framing, parity} (bit 2 down to bit 0).
- R12: `popReq` with an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sixteen-times-baud sample enable |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfgWordLen | input | 2 | Data bits: 00=5 .. 11=8 |
| cfgParEn | input | 1 | Parity bit present |
| cfgParSel | input | 2 | Parity mode: odd, even, forced 1, forced 0 |
| cfgTwoStop | input | 1 | Two stop bits when 1 |
| cfgTrig | input | 2 | Interrupt threshold code |
| fifoClr | input | 1 | Empty the FIFO |
| popReq | input | 1 | Remove the oldest character |
| lsrRead | input | 1 | Status read strobe, clears sticky flags |
| rxData | output | 8 | Oldest character |
| headTags | output | 3 | Oldest character's tags {break, framing, parity} |
| rxLevel | output | 5 | Number of stored characters |
| dataReady | output | 1 | FIFO not empty |
| irqReq | output | 1 | Fill level at or above threshold |
| overrunErr | output | 1 | Sticky overrun flag |
| parityErr | output | 1 | Sticky parity flag |
| framingErr | output | 1 | Sticky framing flag |
| breakInd | output | 1 | Sticky break flag |
| fifoErrAny | output | 1 | Some stored character carries an error |

## Verification
The hardest case to reach is overrun. It needs sixteen complete frames held without a pop, then a seventeenth frame that must vanish without disturbing the stored sequence. The bench drives this by turning its popping monitor off while it fills the FIFO through the trigger-level steps. It checks that the oldest character is still the first one sent, then turns the monitor on so that the scoreboard drains all sixteen entries in order. Break is reached by holding the line low for longer than a full frame. The bench then confirms that only one zero character appears while the line stays low.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int CHAR_W = 8;

  // control -> datapath strobes
  typedef struct packed {
    logic bitStb;   // a data bit was sampled
    logic bitVal;   // its value
    logic doneStb;  // last stop bit sampled, frame complete
    logic parBad;   // parity mismatch in this frame
    logic stopBad;  // a stop sample was 0
    logic brk;      // every sample of the frame was 0
  } rxStrobes_t;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic [CHAR_W-1:0] data;
  } rxEntry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rxState_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxIn,
  input  logic [1:0] cfgWordLen,
  input  logic       cfgParEn,
  input  logic [1:0] cfgParSel,
  input  logic       cfgTwoStop,
  output rxStrobes_t stb
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [2:0]       bitIdx;
  logic             stopIdx;
  logic             parAcc;
  logic             parBadQ;
  logic             stopBadQ;
  logic             allZero;
  logic             armed;

  logic       sampleNow;
  logic [2:0] lastIdx;
  logic       expPar;
  logic       brkNow;

  assign sampleNow = tick && (tickCnt == LAST);
  assign lastIdx   = 3'd4 + {1'b0, cfgWordLen};
  assign brkNow    = allZero & ~rxIn;

  always_comb begin
    case (cfgParSel)
      2'b00:   expPar = ~parAcc;
      2'b01:   expPar = parAcc;
      2'b10:   expPar = 1'b1;
      default: expPar = 1'b0;
    endcase
  end

  always_comb begin
    stb.bitStb  = (state == ST_DATA) && sampleNow;
    stb.bitVal  = rxIn;
    stb.doneStb = (state == ST_STOP) && sampleNow && (stopIdx == cfgTwoStop);
    stb.stopBad = stopBadQ | ~rxIn;
    stb.brk     = brkNow;
    stb.parBad  = parBadQ & ~brkNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      bitIdx   <= '0;
      stopIdx  <= 1'b0;
      parAcc   <= 1'b0;
      parBadQ  <= 1'b0;
      stopBadQ <= 1'b0;
      allZero  <= 1'b1;
      armed    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (rxIn) begin
            armed <= 1'b1;
          end else if (armed) begin
            state   <= ST_START;
            tickCnt <= '0;
            armed   <= 1'b0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (tickCnt == MID) begin
              tickCnt <= '0;
              if (!rxIn) begin
                state    <= ST_DATA;
                bitIdx   <= '0;
                stopIdx  <= 1'b0;
                parAcc   <= 1'b0;
                parBadQ  <= 1'b0;
                stopBadQ <= 1'b0;
                allZero  <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            tickCnt <= sampleNow ? '0 : tickCnt + 1'b1;
            if (sampleNow) begin
              parAcc  <= parAcc ^ rxIn;
              allZero <= allZero & ~rxIn;
              if (bitIdx == lastIdx) state <= cfgParEn ? ST_PAR : ST_STOP;
              else                   bitIdx <= bitIdx + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (tick) begin
            tickCnt <= sampleNow ? '0 : tickCnt + 1'b1;
            if (sampleNow) begin
              parBadQ <= (rxIn != expPar);
              allZero <= allZero & ~rxIn;
              state   <= ST_STOP;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            tickCnt <= sampleNow ? '0 : tickCnt + 1'b1;
            if (sampleNow) begin
              stopBadQ <= stopBadQ | ~rxIn;
              allZero  <= allZero & ~rxIn;
              if (stopIdx == cfgTwoStop) begin
                state <= ST_IDLE;
                armed <= 1'b0;
              end else begin
                stopIdx <= 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_dpath.sv
module serial_rx_dpath
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        stb,
  input  logic [1:0]        cfgWordLen,
  input  logic [1:0]        cfgTrig,
  input  logic              fifoClr,
  input  logic              popReq,
  input  logic              lsrRead,
  output logic [CHAR_W-1:0] rxData,
  output logic [2:0]        headTags,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              dataReady,
  output logic              irqReq,
  output logic              overrunErr,
  output logic              parityErr,
  output logic              framingErr,
  output logic              breakInd,
  output logic              fifoErrAny
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);

  logic [CHAR_W-1:0] shReg;
  rxEntry_t          mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [LVL_W-1:0]  count, errCnt, trigVal;
  rxEntry_t          newEntry, headEntry;
  logic              isFull, doPush, doPop, newHasErr, headHasErr;

  assign newEntry.brk  = stb.brk;
  assign newEntry.frm  = stb.stopBad;
  assign newEntry.par  = stb.parBad;
  assign newEntry.data = shReg >> (2'd3 - cfgWordLen);

  assign isFull     = (count == LVL_FULL);
  assign doPush     = stb.doneStb && !isFull && !fifoClr;
  assign doPop      = popReq && (count != '0) && !fifoClr;
  assign headEntry  = mem[rdPtr];
  assign newHasErr  = newEntry.brk | newEntry.frm | newEntry.par;
  assign headHasErr = headEntry.brk | headEntry.frm | headEntry.par;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else if (stb.bitStb) shReg <= {stb.bitVal, shReg[CHAR_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= newEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      errCnt <= '0;
    end else if (fifoClr) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      errCnt <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      count  <= count + LVL_W'(doPush) - LVL_W'(doPop);
      errCnt <= errCnt + LVL_W'(doPush && newHasErr) - LVL_W'(doPop && headHasErr);
    end
  end

  // sticky line-status flags: read clears, a same-cycle event wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrunErr <= 1'b0;
      parityErr  <= 1'b0;
      framingErr <= 1'b0;
      breakInd   <= 1'b0;
    end else begin
      overrunErr <= (overrunErr & ~lsrRead) | (stb.doneStb & isFull);
      parityErr  <= (parityErr  & ~lsrRead) | (doPush & newEntry.par);
      framingErr <= (framingErr & ~lsrRead) | (doPush & newEntry.frm);
      breakInd   <= (breakInd   & ~lsrRead) | (doPush & newEntry.brk);
    end
  end

  always_comb begin
    case (cfgTrig)
      2'b00:   trigVal = LVL_W'(1);
      2'b01:   trigVal = LVL_W'(4);
      2'b10:   trigVal = LVL_W'(8);
      default: trigVal = LVL_W'(14);
    endcase
  end

  assign rxLevel    = count;
  assign dataReady  = (count != '0);
  assign irqReq     = (count >= trigVal);
  assign fifoErrAny = (errCnt != '0);
  assign rxData     = dataReady ? headEntry.data : '0;
  assign headTags   = dataReady ? {headEntry.brk, headEntry.frm, headEntry.par} : 3'b000;
endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OVS   = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              rxd,
  input  logic [1:0]        cfgWordLen,
  input  logic              cfgParEn,
  input  logic [1:0]        cfgParSel,
  input  logic              cfgTwoStop,
  input  logic [1:0]        cfgTrig,
  input  logic              fifoClr,
  input  logic              popReq,
  input  logic              lsrRead,
  output logic [CHAR_W-1:0] rxData,
  output logic [2:0]        headTags,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              dataReady,
  output logic              irqReq,
  output logic              overrunErr,
  output logic              parityErr,
  output logic              framingErr,
  output logic              breakInd,
  output logic              fifoErrAny
);
  logic       rxMeta, rxSync;
  rxStrobes_t stb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxd;
      rxSync <= rxMeta;
    end
  end

  serial_rx_ctrl #(.OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick16), .rxIn(rxSync),
    .cfgWordLen(cfgWordLen), .cfgParEn(cfgParEn), .cfgParSel(cfgParSel),
    .cfgTwoStop(cfgTwoStop), .stb(stb)
  );

  serial_rx_dpath #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgWordLen(cfgWordLen),
    .cfgTrig(cfgTrig), .fifoClr(fifoClr), .popReq(popReq), .lsrRead(lsrRead),
    .rxData(rxData), .headTags(headTags), .rxLevel(rxLevel),
    .dataReady(dataReady), .irqReq(irqReq), .overrunErr(overrunErr),
    .parityErr(parityErr), .framingErr(framingErr), .breakInd(breakInd),
    .fifoErrAny(fifoErrAny)
  );
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [LVL_W-1:0] rxLevel,
  input logic             dataReady,
  input logic             irqReq,
  input logic             fifoErrAny,
  input logic             overrunErr,
  input logic             parityErr,
  input logic             framingErr,
  input logic             breakInd,
  input logic             fifoClr,
  input logic             popReq,
  input logic             lsrRead,
  input logic             doneStb
);
  a_r6_overrun_when_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> $past(rxLevel) == LVL_W'(DEPTH));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead && !doneStb) |=> !overrunErr && !parityErr && !framingErr && !breakInd);

  a_r8_err_needs_char: assert property (@(posedge clk) disable iff (!rstN)
    fifoErrAny |-> dataReady);

  a_r9_irq_needs_char: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> dataReady);

  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |=> (rxLevel == '0) && !dataReady && !fifoErrAny);

  a_r12_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && rxLevel == '0 && !doneStb && !fifoClr) |=> rxLevel == '0);

  a_r1_level_step: assert property (@(posedge clk) disable iff (!rstN)
    !fifoClr |=> (int'(rxLevel) <= int'($past(rxLevel)) + 1) &&
                 (int'(rxLevel) + 1 >= int'($past(rxLevel))));

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(rxLevel) <= DEPTH);
endmodule

bind serial_rx_top serial_rx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .rxLevel(rxLevel), .dataReady(dataReady),
  .irqReq(irqReq), .fifoErrAny(fifoErrAny), .overrunErr(overrunErr),
  .parityErr(parityErr), .framingErr(framingErr), .breakInd(breakInd),
  .fifoClr(fifoClr), .popReq(popReq), .lsrRead(lsrRead),
  .doneStb(stb.doneStb)
);

// File: tb/serial_rx_top_tb.sv
module serial_rx_top_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN = 1'b0;
  logic [1:0] tickDiv = 2'd0;
  logic       tick16;
  always @(posedge clk) tickDiv <= tickDiv + 2'd1;
  assign tick16 = (tickDiv == 2'd3);

  logic       rxd = 1'b1;
  logic [1:0] cfgWordLen = 2'b11;
  logic       cfgParEn = 1'b0;
  logic [1:0] cfgParSel = 2'b00;
  logic       cfgTwoStop = 1'b0;
  logic [1:0] cfgTrig = 2'b00;
  logic       fifoClr = 1'b0, lsrRead = 1'b0, tbPop = 1'b0, monPop = 1'b0;
  logic       popReq;
  assign popReq = tbPop | monPop;

  logic [7:0] rxData;
  logic [2:0] headTags;
  logic [4:0] rxLevel;
  logic dataReady, irqReq, overrunErr, parityErr, framingErr, breakInd, fifoErrAny;

  serial_rx_top u_dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxd(rxd),
    .cfgWordLen(cfgWordLen), .cfgParEn(cfgParEn), .cfgParSel(cfgParSel),
    .cfgTwoStop(cfgTwoStop), .cfgTrig(cfgTrig), .fifoClr(fifoClr),
    .popReq(popReq), .lsrRead(lsrRead), .rxData(rxData), .headTags(headTags),
    .rxLevel(rxLevel), .dataReady(dataReady), .irqReq(irqReq),
    .overrunErr(overrunErr), .parityErr(parityErr), .framingErr(framingErr),
    .breakInd(breakInd), .fifoErrAny(fifoErrAny)
  );

  int checks = 0;
  int fails = 0;
  bit monOn = 1'b0;
  logic [10:0] expQ[$];
  logic [10:0] expHead;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops each character and compares it with the scoreboard head
  always @(negedge clk) begin
    if (monPop) monPop = 1'b0;
    else if (monOn && rstN && dataReady) begin
      if (expQ.size() == 0) chk("R1 unexpected character", {headTags, rxData}, -1);
      else begin
        expHead = expQ.pop_front();
        chk("R1/R11 head character and tags", {headTags, rxData}, expHead);
      end
      monPop = 1'b1;
    end
  end

  task automatic driveBit(input logic v);
    rxd = v;
    repeat (64) @(negedge clk);
  endtask

  // driver: sends a frame in the current format and queues its expectation
  task automatic sendFrame(input logic [7:0] d, input bit badPar = 0,
                           input bit badStop1 = 0, input bit badStop2 = 0,
                           input bit keep = 1);
    int len;
    logic [7:0] md;
    logic pb;
    len = int'(cfgWordLen) + 5;
    md  = d & 8'((1 << len) - 1);
    case (cfgParSel)
      2'b00:   pb = ~(^md);
      2'b01:   pb = ^md;
      2'b10:   pb = 1'b1;
      default: pb = 1'b0;
    endcase
    if (badPar) pb = ~pb;
    if (keep) expQ.push_back({1'b0, badStop1 | (cfgTwoStop & badStop2), cfgParEn & badPar, md});
    driveBit(1'b0);
    for (int i = 0; i < len; i++) driveBit(md[i]);
    if (cfgParEn) driveBit(pb);
    driveBit(~badStop1);
    if (cfgTwoStop) driveBit(~badStop2);
    rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic pulseLsr();
    lsrRead = 1'b1;
    @(negedge clk);
    lsrRead = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain();
    monOn = 1'b1;
    while (expQ.size() != 0 || dataReady) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic setFmt(input logic [1:0] wl, input logic pe, input logic [1:0] ps,
                        input logic ts);
    cfgWordLen = wl; cfgParEn = pe; cfgParSel = ps; cfgTwoStop = ts;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset dataReady", dataReady, 0);
    chk("R1 reset level", rxLevel, 0);
    chk("R9 reset irq", irqReq, 0);
    chk("R7 reset flags", {overrunErr, parityErr, framingErr, breakInd}, 0);
    chk("R8 reset fifoErrAny", fifoErrAny, 0);

    // R1 R3 R4: several formats through the scoreboard
    monOn = 1'b1;
    setFmt(2'b11, 0, 2'b00, 0);
    sendFrame(8'h55); sendFrame(8'hA3); sendFrame(8'h00); sendFrame(8'hFF);
    setFmt(2'b00, 0, 2'b00, 0); sendFrame(8'hFB);
    setFmt(2'b10, 1, 2'b01, 0); sendFrame(8'h41);
    setFmt(2'b11, 1, 2'b00, 1); sendFrame(8'h3C);
    setFmt(2'b01, 1, 2'b10, 0); sendFrame(8'h2A);
    setFmt(2'b11, 1, 2'b11, 0); sendFrame(8'h81);
    drain();
    chk("R1 all formats consumed", expQ.size(), 0);

    // R3 R8 R11: parity error
    monOn = 1'b0;
    setFmt(2'b11, 1, 2'b01, 0);
    sendFrame(8'h5A, 1);
    chk("R3 parityErr set", parityErr, 1);
    chk("R8 fifoErrAny with bad char", fifoErrAny, 1);
    chk("R11 head tags parity", headTags, 3'b001);
    pulseLsr();
    chk("R7 parityErr cleared", parityErr, 0);
    chk("R8 fifoErrAny kept after read", fifoErrAny, 1);
    drain();
    chk("R8 fifoErrAny after pop", fifoErrAny, 0);

    // R4: framing error, one and two stop bits
    monOn = 1'b0;
    setFmt(2'b11, 0, 2'b00, 0);
    sendFrame(8'h33, 0, 1);
    chk("R4 framingErr one stop", framingErr, 1);
    chk("R11 head tags framing", headTags, 3'b010);
    pulseLsr();
    chk("R7 framingErr cleared", framingErr, 0);
    setFmt(2'b11, 0, 2'b00, 1);
    sendFrame(8'h44, 0, 0, 1);
    chk("R4 framingErr second stop", framingErr, 1);
    pulseLsr();
    drain();

    // R2: short low pulse is rejected, then a real frame is accepted
    setFmt(2'b11, 0, 2'b00, 0);
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (700) @(negedge clk);
    chk("R2 glitch gives no character", rxLevel, 0);
    sendFrame(8'h96);
    drain();
    chk("R2 frame after glitch", expQ.size(), 0);

    // R5: break
    monOn = 1'b0;
    rxd = 1'b0;
    repeat (12 * 64) @(negedge clk);
    chk("R5 breakInd", breakInd, 1);
    chk("R5 one zero char tagged", {headTags, rxData}, 11'h600);
    repeat (640) @(negedge clk);
    chk("R5 single char while low", rxLevel, 1);
    rxd = 1'b1;
    repeat (24) @(negedge clk);
    pulseLsr();
    chk("R7 break flags cleared", {breakInd, framingErr}, 0);
    fifoClr = 1'b1;
    @(negedge clk);
    fifoClr = 1'b0;
    chk("R10 clear level", rxLevel, 0);
    chk("R10 clear ready/err", {dataReady, fifoErrAny}, 0);

    // R9: trigger levels
    cfgTrig = 2'b01;
    for (int i = 0; i < 3; i++) sendFrame(8'(8'h10 + i));
    chk("R9 below 4", irqReq, 0);
    sendFrame(8'h13);
    chk("R9 at 4", irqReq, 1);
    cfgTrig = 2'b10;
    @(negedge clk);
    chk("R9 below 8", irqReq, 0);
    cfgTrig = 2'b11;
    for (int i = 0; i < 9; i++) sendFrame(8'(8'h20 + i));
    chk("R9 below 14", irqReq, 0);
    sendFrame(8'h29);
    chk("R9 at 14", irqReq, 1);

    // R6: overrun
    sendFrame(8'h2A); sendFrame(8'h2B);
    chk("R6 full level", rxLevel, 16);
    chk("R6 no overrun yet", overrunErr, 0);
    sendFrame(8'hEE, 0, 0, 0, 0);
    chk("R6 overrunErr", overrunErr, 1);
    chk("R6 level unchanged", rxLevel, 16);
    chk("R6 oldest kept", {headTags, rxData}, expQ[0]);
    pulseLsr();
    chk("R7 overrun cleared", overrunErr, 0);
    drain();
    chk("R6 lost char absent", rxLevel, 0);

    // R12: pop on empty
    monOn = 1'b0;
    tbPop = 1'b1;
    @(negedge clk);
    tbPop = 1'b0;
    @(negedge clk);
    chk("R12 empty pop level", rxLevel, 0);
    chk("R12 empty pop ready", dataReady, 0);
    sendFrame(8'h77);
    chk("R12 push after empty pop", rxLevel, 1);
    drain();

    summary();
  end
endmodule